// File: doc/BRIEF.md
# Outstanding Request Deadlock Watchdog

This block supervises a small table of memory requests that are in flight. Reads and writes sit in two separate groups. Each valid slot carries the cycle stamp at which its request was issued, taken from the block's own free-running cycle counter. The allocator pulses an insertion strobe whenever it accepts a request.

That strobe starts a check timer, unless a check is already pending or the system is draining. One threshold period later, every slot of both groups is aged against the current cycle. If a slot has waited at least the threshold, a sticky deadlock flag rises and the lowest offending slot index is latched.

After each check the timer restarts, but only while the allocator still reports outstanding work. The block also flags, stickily, any cycle in which the allocator's outstanding count disagrees with the number of valid slots.

Top module: `dl_watchdog`

## Requirements
- R1: Reset clears `time_o`, `deadlock_o`, `cnt_err_o` and `chk_o` to 0. After reset, `time_o` increases by one every cycle, modulo 2^TW.
- R2: An `ins_i` pulse arms a check only when no check is pending and `drain_i` is low. A pulse seen while draining is dropped. A pulse seen while a check is pending does not restart the period.
- R3: An armed check runs in the cycle whose `time_o` equals the arming cycle's `time_o` plus THRESH, with `chk_o` high in that cycle. A resulting deadlock shows on `deadlock_o` in the following cycle.
- R4: A slot counts as expired when it is valid and (check-cycle time minus its stamp) modulo 2^TW is at least THRESH. A slot aged THRESH-1 is not expired, and an invalid slot is never expired, whatever its stamp.
- R5: Every check examines both groups. Read slot i has index i and write slot j has index RD_N+j. When several slots are expired, `dl_idx_o` takes the lowest index.
- R6: After a check, a new check is armed THRESH cycles later if `out_cnt_i` is nonzero in the check cycle. Otherwise the block goes idle and runs no further check until the next insertion.
- R7: No check runs in a cycle with `drain_i` high. A check that falls due while draining runs in the first cycle in which `drain_i` is low.
- R8: Once set, `deadlock_o` and `dl_idx_o` keep their values until reset, even if later checks find other expired slots.
- R9: `cnt_err_o` rises in the cycle after `out_cnt_i` differs from the number of valid slots in both groups, and stays high until reset.
- R10: Aging is correct across wraparound of the cycle counter, for example a slot stamped 250 with TW=8 and THRESH=8 is expired at time 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_i | input | 1 | Request insertion strobe from the allocator |
| drain_i | input | 1 | System is draining; checks are held off |
| rd_valid_i | input | RD_N | Valid bits of the read slots |
| wr_valid_i | input | WR_N | Valid bits of the write slots |
| rd_stamp_i | input | RD_N*TW | Issue stamps of the read slots, slot i at bits [i*TW +: TW] |
| wr_stamp_i | input | WR_N*TW | Issue stamps of the write slots, slot j at bits [j*TW +: TW] |
| out_cnt_i | input | clog2(RD_N+WR_N+1) | Allocator's count of outstanding requests |
| time_o | output | TW | Free-running cycle count used for stamping |
| chk_o | output | 1 | High in the cycle a check is evaluated |
| deadlock_o | output | 1 | Sticky deadlock flag |
| dl_idx_o | output | clog2(RD_N+WR_N) | Lowest expired slot index at the first deadlock |
| cnt_err_o | output | 1 | Sticky outstanding-count mismatch flag |

## Verification
The assertions check the following on every cycle:
- the scheduler's transitions: arming from idle, refusal while draining, restart or stop after a check, and a due check being held through drain;
- the stickiness of the deadlock flag, its index and the count-error flag;
- the cycle counter's step.

The exact distance of THRESH cycles from arming to check, the age boundary at THRESH-1 versus THRESH, and the choice of the lowest index across both groups show only in the bench's scenarios. The same holds for the ignored second insertion and for behaviour across counter wraparound.

// File: rtl/dlwd_pkg.sv
package dlwd_pkg;
  // Check scheduler state
  typedef enum logic {
    SCH_IDLE  = 1'b0,
    SCH_ARMED = 1'b1
  } sched_e;
endpackage

// File: rtl/dlwd_rst_sync.sv
module dlwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/dlwd_timebase.sv
module dlwd_timebase #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] now_o
);
  logic [TW-1:0] now_q, now_d;

  always_comb now_d = now_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_d;
  end

  assign now_o = now_q;

  // R1: counter advances by exactly one per cycle
  a_r1_tick: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now_q == TW'($past(now_q) + 1'b1));
endmodule

// File: rtl/dlwd_sched.sv
module dlwd_sched
  import dlwd_pkg::*;
#(
  parameter int unsigned THRESH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_i,
  input  logic drain_i,
  input  logic busy_i,
  output logic check_o
);
  localparam int unsigned    WW   = (THRESH > 1) ? $clog2(THRESH) : 1;
  localparam logic [WW-1:0]  LAST = WW'(THRESH - 1);

  sched_e        st_q, st_d;
  logic          st_en;
  logic [WW-1:0] wt_q, wt_d;
  logic          wt_en;
  logic          due;

  always_comb begin
    due     = (st_q == SCH_ARMED) && (wt_q == LAST);
    check_o = due && !drain_i;
  end

  // next state
  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    wt_d  = wt_q;
    wt_en = 1'b0;
    case (st_q)
      SCH_IDLE: begin
        if (ins_i && !drain_i) begin
          st_d  = SCH_ARMED;
          st_en = 1'b1;
          wt_d  = '0;
          wt_en = 1'b1;
        end
      end
      SCH_ARMED: begin
        if (check_o) begin
          st_d  = busy_i ? SCH_ARMED : SCH_IDLE;
          st_en = 1'b1;
          wt_d  = '0;
          wt_en = 1'b1;
        end else if (!due) begin
          wt_d  = wt_q + 1'b1;
          wt_en = 1'b1;
        end
      end
      default: begin
        st_d  = SCH_IDLE;
        st_en = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SCH_IDLE;
      wt_q <= '0;
    end else begin
      if (st_en) st_q <= st_d;
      if (wt_en) wt_q <= wt_d;
    end
  end

  // R2: an insertion while idle and not draining arms a fresh period
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SCH_IDLE && ins_i && !drain_i) |=> (st_q == SCH_ARMED && wt_q == '0));
  // R2: nothing arms while draining
  a_r2_drain_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SCH_IDLE && drain_i) |=> st_q == SCH_IDLE);
  // R6: restart while work is outstanding
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (check_o && busy_i) |=> (st_q == SCH_ARMED && wt_q == '0));
  // R6: go idle when nothing is outstanding
  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (check_o && !busy_i) |=> st_q == SCH_IDLE);
  // R7: a due check is held, not lost, while draining
  a_r7_hold_due: assert property (@(posedge clk) disable iff (!rst_n)
    (due && drain_i) |=> due);
endmodule

// File: rtl/dlwd_scan.sv
module dlwd_scan #(
  parameter int unsigned NE     = 8,
  parameter int unsigned TW     = 16,
  parameter int unsigned THRESH = 64,
  parameter int unsigned IW     = 3
) (
  input  logic [NE-1:0]    valid_i,
  input  logic [NE*TW-1:0] stamp_i,
  input  logic [TW-1:0]    now_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  localparam logic [TW-1:0] LIM = TW'(THRESH);

  logic [NE-1:0] exp_w;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    logic [TW-1:0] age;
    assign age      = now_i - stamp_i[e*TW +: TW];
    assign exp_w[e] = valid_i[e] && (age >= LIM);
  end

  // lowest expired index wins
  always_comb begin
    hit_o = |exp_w;
    idx_o = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (exp_w[e]) idx_o = IW'(e);
    end
  end
endmodule

// File: rtl/dl_watchdog.sv
module dl_watchdog #(
  parameter int unsigned RD_N   = 4,
  parameter int unsigned WR_N   = 4,
  parameter int unsigned TW     = 16,
  parameter int unsigned THRESH = 64,
  localparam int unsigned NE    = RD_N + WR_N,
  localparam int unsigned IW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int unsigned CW    = $clog2(NE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_i,
  input  logic             drain_i,
  input  logic [RD_N-1:0]  rd_valid_i,
  input  logic [WR_N-1:0]  wr_valid_i,
  input  logic [RD_N*TW-1:0] rd_stamp_i,
  input  logic [WR_N*TW-1:0] wr_stamp_i,
  input  logic [CW-1:0]    out_cnt_i,
  output logic [TW-1:0]    time_o,
  output logic             chk_o,
  output logic             deadlock_o,
  output logic [IW-1:0]    dl_idx_o,
  output logic             cnt_err_o
);
  logic          srst_n;
  logic [NE-1:0] vld;
  logic [NE*TW-1:0] stamps;
  logic          busy;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [CW-1:0] live_cnt;
  logic          mismatch;

  logic          dl_q, dl_d, dl_en;
  logic [IW-1:0] idx_q, idx_d;
  logic          err_q, err_d, err_en;

  dlwd_rst_sync u_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n_o (srst_n)
  );

  dlwd_timebase #(.TW(TW)) u_time (
    .clk   (clk),
    .rst_n (srst_n),
    .now_o (time_o)
  );

  assign vld    = {wr_valid_i, rd_valid_i};
  assign stamps = {wr_stamp_i, rd_stamp_i};
  assign busy   = |out_cnt_i;

  dlwd_sched #(.THRESH(THRESH)) u_sched (
    .clk     (clk),
    .rst_n   (srst_n),
    .ins_i   (ins_i),
    .drain_i (drain_i),
    .busy_i  (busy),
    .check_o (chk_o)
  );

  dlwd_scan #(.NE(NE), .TW(TW), .THRESH(THRESH), .IW(IW)) u_scan (
    .valid_i (vld),
    .stamp_i (stamps),
    .now_i   (time_o),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  // next state
  always_comb begin
    live_cnt = CW'($countones(vld));
    mismatch = (live_cnt != out_cnt_i);
    dl_en    = chk_o && hit && !dl_q;
    dl_d     = 1'b1;
    idx_d    = hit_idx;
    err_en   = mismatch && !err_q;
    err_d    = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dl_q  <= 1'b0;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (dl_en) begin
        dl_q  <= dl_d;
        idx_q <= idx_d;
      end
      if (err_en) err_q <= err_d;
    end
  end

  assign deadlock_o = dl_q;
  assign dl_idx_o   = idx_q;
  assign cnt_err_o  = err_q;

  // R8: deadlock flag never clears before reset
  a_r8_dl_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    deadlock_o |=> deadlock_o);
  // R8: reported index is frozen once flagged
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!srst_n)
    deadlock_o |=> $stable(dl_idx_o));
  // R3: the flag only rises right after a check
  a_r3_dl_after_check: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(deadlock_o) |-> $past(chk_o));
  // R5: a check that finds an expired slot always sets the flag
  a_r5_hit_flags: assert property (@(posedge clk) disable iff (!srst_n)
    (chk_o && hit) |=> deadlock_o);
  // R9: count error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_err_o |=> cnt_err_o);
  // R9: count error rises only after a real disagreement
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cnt_err_o) |-> $past(out_cnt_i != CW'($countones(vld))));
endmodule

// File: tb/sim_dl_watchdog.sv
module sim_dl_watchdog;
  localparam int CLK_P = 10;
  localparam int RD    = 4;
  localparam int WR    = 4;
  localparam int TW    = 8;
  localparam int TH    = 8;
  localparam int NE    = RD + WR;
  localparam int IW    = 3;
  localparam int CW    = 4;
  localparam int NV    = 8;

  // vector fields: [7:0] valid mask, [15:8] old-stamp mask, [23:16] expected index, [24] expected deadlock
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd0, 8'h01, 8'h01},
    {1'b1, 8'd7, 8'h80, 8'h80},
    {1'b1, 8'd2, 8'h14, 8'h16},
    {1'b1, 8'd4, 8'h30, 8'hFF},
    {1'b0, 8'd0, 8'h00, 8'h0F},
    {1'b1, 8'd6, 8'h40, 8'h60},
    {1'b1, 8'd3, 8'h88, 8'hAA},
    {1'b1, 8'd1, 8'h03, 8'h02}
  };

  logic clk = 1'b0;
  logic rst_n, ins, drain;
  logic [RD-1:0] rv;
  logic [WR-1:0] wv;
  logic [TW-1:0] st [NE];
  logic [RD*TW-1:0] rs;
  logic [WR*TW-1:0] ws;
  logic [CW-1:0] cnt;
  logic [TW-1:0] time_w;
  logic chk_w, dl_w, err_w;
  logic [IW-1:0] idx_w;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P / 2) clk = ~clk;

  for (genvar g = 0; g < RD; g++) begin : g_rs
    assign rs[g*TW +: TW] = st[g];
  end
  for (genvar g = 0; g < WR; g++) begin : g_ws
    assign ws[g*TW +: TW] = st[RD + g];
  end

  dl_watchdog #(.RD_N(RD), .WR_N(WR), .TW(TW), .THRESH(TH)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_i      (ins),
    .drain_i    (drain),
    .rd_valid_i (rv),
    .wr_valid_i (wv),
    .rd_stamp_i (rs),
    .wr_stamp_i (ws),
    .out_cnt_i  (cnt),
    .time_o     (time_w),
    .chk_o      (chk_w),
    .deadlock_o (dl_w),
    .dl_idx_o   (idx_w),
    .cnt_err_o  (err_w)
  );

  task automatic expect_eq(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ins = 1'b0; drain = 1'b0; rv = '0; wv = '0; cnt = '0;
    for (int e = 0; e < NE; e++) st[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic load(input logic [7:0] vm, input logic [7:0] om, input logic [TW-1:0] t0);
    for (int e = 0; e < NE; e++) st[e] = om[e] ? t0 : TW'(t0 + 1'b1);
    rv  = vm[3:0];
    wv  = vm[7:4];
    cnt = CW'($countones(vm));
  endtask

  // returns cycles from the arming cycle to the first chk_o, or -1
  task automatic wait_chk(input int lim, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) ins = 1'b0;
      #1;
      if (chk_w) return;
      if (n >= lim) begin
        n = -1;
        return;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [TW-1:0] t0, a;
    int n, first, second, nchk;

    // R1: reset state
    rst_n = 1'b0; ins = 1'b0; drain = 1'b0; rv = '0; wv = '0; cnt = '0;
    for (int e = 0; e < NE; e++) st[e] = '0;
    repeat (2) @(negedge clk);
    #1;
    expect_eq("R1 reset time", time_w, 0);
    expect_eq("R1 reset deadlock", dl_w, 0);
    expect_eq("R1 reset cnt_err", err_w, 0);
    expect_eq("R1 reset chk", chk_w, 0);

    // R1: counter steps by one
    do_reset();
    a = time_w;
    step();
    expect_eq("R1 time step", time_w, (int'(a) + 1) % 256);

    // R3 R4 R5 R9: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      t0 = time_w;
      load(VEC[i][7:0], VEC[i][15:8], t0);
      ins = 1'b1;
      wait_chk(3 * TH, n);
      expect_eq("R3 check delay", n, TH);
      expect_eq("R3 time at check", time_w, (int'(t0) + TH) % 256);
      step();
      expect_eq("R4 R5 deadlock", dl_w, int'(VEC[i][24]));
      if (VEC[i][24]) expect_eq("R5 lowest index", idx_w, int'(VEC[i][23:16]));
      expect_eq("R9 no count error", err_w, 0);
    end

    // R2: insertion during drain is dropped
    do_reset();
    t0 = time_w;
    load(8'h01, 8'h01, t0);
    drain = 1'b1;
    ins = 1'b1;
    step();
    ins = 1'b0;
    step();
    drain = 1'b0;
    wait_chk(3 * TH, n);
    expect_eq("R2 drained insert not armed", n, -1);
    expect_eq("R2 no deadlock without check", dl_w, 0);

    // R2 R6: second insertion does not restart; idle after check with zero count
    do_reset();
    ins = 1'b1;
    first = -1; nchk = 0;
    for (int k = 1; k <= 3 * TH; k++) begin
      @(negedge clk);
      ins = (k == 3);
      #1;
      if (chk_w) begin
        nchk++;
        if (first < 0) first = k;
      end
    end
    expect_eq("R2 pending not restarted", first, TH);
    expect_eq("R6 idle when count zero", nchk, 1);

    // R7: due check deferred by drain
    do_reset();
    ins = 1'b1;
    first = -1; nchk = 0;
    for (int k = 1; k <= 3 * TH; k++) begin
      @(negedge clk);
      ins   = 1'b0;
      drain = (k >= TH - 2) && (k <= TH + 2);
      #1;
      if (chk_w && drain) nchk++;
      if (chk_w && first < 0) first = k;
    end
    expect_eq("R7 no check while draining", nchk, 0);
    expect_eq("R7 deferred check cycle", first, TH + 3);

    // R6 R4: re-arm with work outstanding; young slot expires on second check
    do_reset();
    t0 = time_w;
    load(8'h02, 8'h00, t0);
    ins = 1'b1;
    first = -1; second = -1;
    for (int k = 1; k <= 2 * TH + 2; k++) begin
      @(negedge clk);
      ins = 1'b0;
      #1;
      if (k == TH + 1) expect_eq("R4 age THRESH-1 not expired", dl_w, 0);
      if (chk_w) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    expect_eq("R6 first check", first, TH);
    expect_eq("R6 rearmed check", second, 2 * TH);
    expect_eq("R6 deadlock after rearm", dl_w, 1);
    expect_eq("R5 read slot index", idx_w, 1);

    // R8: sticky flag and index
    do_reset();
    t0 = time_w;
    load(8'h04, 8'h04, t0);
    ins = 1'b1;
    wait_chk(3 * TH, n);
    step();
    expect_eq("R8 first deadlock", dl_w, 1);
    expect_eq("R8 first index", idx_w, 2);
    rv = 4'b0001;
    st[0] = t0;
    cnt = 1;
    wait_chk(3 * TH, n);
    expect_eq("R8 later check timing", n, TH - 1);
    step();
    expect_eq("R8 deadlock stays", dl_w, 1);
    expect_eq("R8 index unchanged", idx_w, 2);

    // R9: count mismatch
    do_reset();
    rv = 4'b0001;
    cnt = 1;
    step();
    expect_eq("R9 consistent count", err_w, 0);
    cnt = 2;
    step();
    expect_eq("R9 mismatch flagged", err_w, 1);
    cnt = 1;
    step();
    expect_eq("R9 flag sticky", err_w, 1);

    // R10: wraparound
    do_reset();
    while (time_w != TW'(250)) step();
    t0 = time_w;
    load(8'h03, 8'h01, t0);
    ins = 1'b1;
    wait_chk(3 * TH, n);
    expect_eq("R10 check delay across wrap", n, TH);
    expect_eq("R10 wrapped time", time_w, 2);
    step();
    expect_eq("R10 deadlock across wrap", dl_w, 1);
    expect_eq("R10 index across wrap", idx_w, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule